// File: doc/BRIEF.md
# Delayed Register-Update Queue

This block holds writes to architectural state that must land a set number of timing ticks after they are issued, which is how a pipeline models late-arriving results such as a condition flag or a register that a coprocessor updates some cycles after the instruction that produced it. Each entry carries a destination index, a tick count, and either a single-bit set/clear or a whole-word update of 32 or 64 bits. The queue counts every held entry down on each cycle where `tick` is high. When an entry's count expires, the queue presents its write on a mask-and-data write port that feeds an external register file.

Storage is a ring of slots. Entries are taken in at the tail and reclaimed only at the head. Entries expire independently, so a short-delay entry can be written before an older long-delay one. Its slot is nevertheless kept until everything older than it has been written. Writes leave one per cycle. When several are ready at once, they go in ring order starting from the head. The receiving register file applies `new = (old & ~wr_mask) | (wr_data & wr_mask)`.

A four-state controller governs the queue. `ST_EMPTY` means no entries are held. `ST_COUNT` means entries are held and none is waiting to be written. `ST_WRITE` means at least one expired entry is waiting for the write port. `ST_FAULT` is a sticky trap state and can be left only by reset.

The controller moves as follows:
- EMPTY goes to COUNT on an accepted entry.
- COUNT goes to WRITE when an entry expires.
- WRITE returns to COUNT when no expired entry is left.
- COUNT or WRITE returns to EMPTY when the last slot is reclaimed.
- Any state goes to FAULT when the tail pointer differs from head plus occupancy, modulo the slot count. This covers the case where the pointers differ while the occupancy is zero.

Top module: `delay_wr_queue`

## Requirements
- R1: After reset the queue is empty: `enq_full`, `wr_en` and `fault` are all 0.
- R2: An entry offered with `enq_valid` is accepted when `enq_full` is 0. `enq_full` is 1 exactly when SLOTS entries are held. An entry offered while `enq_full` is 1 is dropped and never produces a write.
- R3: Countdown happens only on cycles where `tick` is 1. An entry with delay D (D = 0 is treated as 1) expires on the D-th tick edge after the edge that accepted it. Its write is on the port (`wr_en` = 1) in the cycle that follows the next clock edge.
- R4: In bit mode (`enq_bit_mode` = 1) with a nonzero value, the write is a set: `wr_mask` = `wr_data` = 1 << bit.
- R5: In bit mode with a value of zero, the write is a clear: `wr_mask` = 1 << bit and `wr_data` = 0, so that only that bit changes.
- R6: In word mode (`enq_bit_mode` = 0), a 64-bit entry (`enq_wide` = 1) gives an all-ones `wr_mask` and `wr_data` = value. A 32-bit entry (`enq_wide` = 0) gives `wr_mask` = 0x00000000FFFFFFFF and `wr_data` = value with bits 63..32 cleared.
- R7: In bit mode with `enq_wide` = 0, the bit index is taken modulo 32.
- R8: At most one write per cycle. Entries expiring on the same tick are written on consecutive cycles in ring order from the head, which is acceptance order.
- R9: An entry expires and is written independently of older entries. Its slot is not reclaimed while an older entry is still unwritten, so `enq_full` stays 1 while the oldest entry is pending.
- R10: Slots are reclaimed in order, one per cycle, from the cycle after the head entry is written. When the oldest of a full queue is written, `enq_full` falls on the following edge, and all SLOTS slots become reusable.
- R11: `fault` rises and stays high if the tail pointer is not head plus occupancy (mod SLOTS). In fault, nothing is counted, written, taken in or reclaimed. No legal sequence of inputs raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Countdown strobe |
| enq_valid | input | 1 | Offer an entry |
| enq_dest | input | DEST_W | Destination register index |
| enq_delay | input | DELAY_W | Ticks until the write (0 acts as 1) |
| enq_bit_mode | input | 1 | 1: single-bit update, 0: whole word |
| enq_bit | input | BIT_W | Bit position for bit mode |
| enq_wide | input | 1 | 1: 64-bit size, 0: 32-bit size |
| enq_value | input | DATA_W | Word value, or nonzero/zero for set/clear |
| enq_full | output | 1 | All slots held; entries are dropped |
| wr_en | output | 1 | Write port strobe |
| wr_dest | output | DEST_W | Write destination index |
| wr_mask | output | DATA_W | Bits to change |
| wr_data | output | DATA_W | New bit values under the mask |
| fault | output | 1 | Sticky pointer-inconsistency trap |

## Verification
The hardest condition to reach is a full ring whose head entry is still counting while every younger entry has already expired and been written. This is the only case where reclaim order differs visibly from write order. The stimulus produces it with a 15-tick entry followed by seven 1-tick entries. It then checks the sequence of writes, checks that `enq_full` holds until the exact cycle after the head's write, checks that an entry offered during that window never appears, and checks that eight fresh entries fit afterwards. Coincident expiry is produced by holding `tick` low while several entries are loaded, then releasing it, so that they all expire on the same edge.

// File: rtl/dwq_pkg.sv
package dwq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_COUNT,
        ST_WRITE,
        ST_FAULT
    } dwq_state_e;

    typedef enum logic [1:0] {
        WK_SETBIT,
        WK_CLRBIT,
        WK_WORD32,
        WK_WORD64
    } wr_kind_e;

endpackage

// File: rtl/dwq_slot.sv
module dwq_slot #(
    parameter int DEST_W  = 5,
    parameter int DELAY_W = 4,
    parameter int BIT_W   = 6,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DEST_W-1:0] dest_i,
    input  logic [DELAY_W-1:0] delay_i,
    input  logic              bitmode_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic              tick_i,
    input  logic              issue_i,
    input  logic              free_i,
    output logic              valid_o,
    output logic              pend_o,
    output logic              done_o,
    output logic              pend_nxt_o,
    output logic [DEST_W-1:0] dest_o,
    output logic              bitmode_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic              wide_o,
    output logic [DATA_W-1:0] value_o
);

    logic               valid_q, valid_d;
    logic               pend_q, pend_d;
    logic               done_q, done_d;
    logic [DELAY_W-1:0] delay_q, delay_d;

    // life of a slot: free -> counting -> pending -> done -> free
    always_comb begin
        valid_d = valid_q;
        pend_d  = pend_q;
        done_d  = done_q;
        delay_d = delay_q;
        if (free_i) begin
            valid_d = 1'b0;
            pend_d  = 1'b0;
            done_d  = 1'b0;
        end else if (load_i) begin
            valid_d = 1'b1;
            pend_d  = 1'b0;
            done_d  = 1'b0;
            delay_d = (delay_i == '0) ? DELAY_W'(1) : delay_i;
        end else if (issue_i) begin
            pend_d = 1'b0;
            done_d = 1'b1;
        end else if (tick_i && valid_q && !pend_q && !done_q) begin
            if (delay_q <= DELAY_W'(1)) begin
                delay_d = '0;
                pend_d  = 1'b1;
            end else begin
                delay_d = delay_q - DELAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            delay_q <= '0;
        end else begin
            valid_q <= valid_d;
            pend_q  <= pend_d;
            done_q  <= done_d;
            delay_q <= delay_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_o    <= '0;
            bitmode_o <= 1'b0;
            bit_o     <= '0;
            wide_o    <= 1'b0;
            value_o   <= '0;
        end else if (load_i) begin
            dest_o    <= dest_i;
            bitmode_o <= bitmode_i;
            bit_o     <= bit_i;
            wide_o    <= wide_i;
            value_o   <= value_i;
        end
    end

    assign valid_o    = valid_q;
    assign pend_o     = pend_q;
    assign done_o     = done_q;
    assign pend_nxt_o = pend_d;

    AST_PEND_VALID: assert property (@(posedge clk) disable iff (!rst_n) pend_q |-> valid_q); // R3
    AST_ISSUE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) issue_i |-> pend_q); // R8
    AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n) load_i |-> !valid_q); // R2
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pend_q && done_q)); // R10

endmodule

// File: rtl/dwq_pick.sv
module dwq_pick #(
    parameter int SLOTS = 8,
    parameter int PTR_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] req_i,
    input  logic [PTR_W-1:0] base_i,
    output logic             any_o,
    output logic [PTR_W-1:0] idx_o
);

    function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] a, input int b);
        logic [PTR_W:0] s;
        s = {1'b0, a} + (PTR_W+1)'(b);
        if (s >= (PTR_W+1)'(SLOTS)) s = s - (PTR_W+1)'(SLOTS);
        return s[PTR_W-1:0];
    endfunction

    logic [SLOTS-1:0] rot;
    logic [PTR_W-1:0] off;
    logic             found;

    // rotate so that position 0 is the head slot
    for (genvar g = 0; g < SLOTS; g++) begin : g_rot
        assign rot[g] = req_i[ring_add(base_i, g)];
    end

    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!found && rot[i]) begin
                found = 1'b1;
                off   = PTR_W'(i);
            end
        end
    end

    assign any_o = found;
    assign idx_o = ring_add(base_i, int'(off));

endmodule

// File: rtl/dwq_fmt.sv
module dwq_fmt
    import dwq_pkg::*;
#(
    parameter int BIT_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic              bitmode_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int HALF = DATA_W / 2;
    localparam logic [BIT_W-1:0]  NARROW_BITS = BIT_W'(HALF - 1);
    localparam logic [DATA_W-1:0] LOW_ONES    = {{HALF{1'b0}}, {HALF{1'b1}}};

    wr_kind_e          kind;
    logic [BIT_W-1:0]  eff_bit;
    logic [DATA_W-1:0] onehot;

    assign eff_bit = wide_i ? bit_i : (bit_i & NARROW_BITS);
    assign onehot  = {{(DATA_W-1){1'b0}}, 1'b1} << eff_bit;

    always_comb begin
        if (bitmode_i) kind = (value_i != '0) ? WK_SETBIT : WK_CLRBIT;
        else           kind = wide_i ? WK_WORD64 : WK_WORD32;
    end

    always_comb begin
        unique case (kind)
            WK_SETBIT: begin mask_o = onehot;        data_o = onehot;             end
            WK_CLRBIT: begin mask_o = onehot;        data_o = '0;                 end
            WK_WORD32: begin mask_o = LOW_ONES;      data_o = value_i & LOW_ONES; end
            WK_WORD64: begin mask_o = '1;            data_o = value_i;            end
        endcase
    end

endmodule

// File: rtl/delay_wr_queue.sv
module delay_wr_queue
    import dwq_pkg::*;
#(
    parameter int SLOTS   = 8,
    parameter int DEST_W  = 5,
    parameter int DELAY_W = 4,
    parameter int DATA_W  = 64,
    parameter int BIT_W   = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               enq_valid,
    input  logic [DEST_W-1:0]  enq_dest,
    input  logic [DELAY_W-1:0] enq_delay,
    input  logic               enq_bit_mode,
    input  logic [BIT_W-1:0]   enq_bit,
    input  logic               enq_wide,
    input  logic [DATA_W-1:0]  enq_value,
    output logic               enq_full,
    output logic               wr_en,
    output logic [DEST_W-1:0]  wr_dest,
    output logic [DATA_W-1:0]  wr_mask,
    output logic [DATA_W-1:0]  wr_data,
    output logic               fault
);

    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [DATA_W-1:0] LOW_ONES = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

    function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] a, input logic [CNT_W-1:0] b);
        logic [PTR_W+CNT_W:0] s;
        s = (PTR_W+CNT_W+1)'(a) + (PTR_W+CNT_W+1)'(b);
        if (s >= (PTR_W+CNT_W+1)'(SLOTS)) s = s - (PTR_W+CNT_W+1)'(SLOTS);
        return s[PTR_W-1:0];
    endfunction

    dwq_state_e       st_q, st_d;
    logic [PTR_W-1:0] in_q, out_q, in_d, out_d;
    logic [CNT_W-1:0] total_q, total_d;

    logic [SLOTS-1:0] s_valid, s_pend, s_done, s_pend_nxt;
    logic [SLOTS-1:0] s_load, s_issue, s_free;
    logic [DEST_W-1:0] s_dest    [SLOTS];
    logic              s_bitmode [SLOTS];
    logic [BIT_W-1:0]  s_bit     [SLOTS];
    logic              s_wide    [SLOTS];
    logic [DATA_W-1:0] s_value   [SLOTS];

    logic run, issue_ok, accept_ok;
    logic enq_go, issue_go, free_go, tick_en, mismatch;
    logic pick_any;
    logic [PTR_W-1:0] pick_idx;
    logic [DATA_W-1:0] fmt_mask, fmt_data;

    // controller permissions per state
    always_comb begin
        unique case (st_q)
            ST_EMPTY: begin run = 1'b0; issue_ok = 1'b0; accept_ok = 1'b1; end
            ST_COUNT: begin run = 1'b1; issue_ok = 1'b0; accept_ok = 1'b1; end
            ST_WRITE: begin run = 1'b1; issue_ok = 1'b1; accept_ok = 1'b1; end
            ST_FAULT: begin run = 1'b0; issue_ok = 1'b0; accept_ok = 1'b0; end
        endcase
    end

    assign enq_full = (total_q == CNT_W'(SLOTS));
    assign enq_go   = enq_valid && !enq_full && accept_ok;
    assign tick_en  = tick && run;
    assign issue_go = issue_ok && pick_any;
    assign free_go  = run && s_valid[out_q] && s_done[out_q];
    assign mismatch = (in_q != ring_add(out_q, total_q));

    dwq_pick #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_pick (
        .req_i (s_pend),
        .base_i(out_q),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign s_load[g]  = enq_go   && (in_q     == PTR_W'(g));
        assign s_issue[g] = issue_go && (pick_idx == PTR_W'(g));
        assign s_free[g]  = free_go  && (out_q    == PTR_W'(g));

        dwq_slot #(
            .DEST_W(DEST_W), .DELAY_W(DELAY_W), .BIT_W(BIT_W), .DATA_W(DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (s_load[g]),
            .dest_i    (enq_dest),
            .delay_i   (enq_delay),
            .bitmode_i (enq_bit_mode),
            .bit_i     (enq_bit),
            .wide_i    (enq_wide),
            .value_i   (enq_value),
            .tick_i    (tick_en),
            .issue_i   (s_issue[g]),
            .free_i    (s_free[g]),
            .valid_o   (s_valid[g]),
            .pend_o    (s_pend[g]),
            .done_o    (s_done[g]),
            .pend_nxt_o(s_pend_nxt[g]),
            .dest_o    (s_dest[g]),
            .bitmode_o (s_bitmode[g]),
            .bit_o     (s_bit[g]),
            .wide_o    (s_wide[g]),
            .value_o   (s_value[g])
        );
    end

    dwq_fmt #(.BIT_W(BIT_W), .DATA_W(DATA_W)) u_fmt (
        .bitmode_i(s_bitmode[pick_idx]),
        .bit_i    (s_bit[pick_idx]),
        .wide_i   (s_wide[pick_idx]),
        .value_i  (s_value[pick_idx]),
        .mask_o   (fmt_mask),
        .data_o   (fmt_data)
    );

    // ring bookkeeping
    always_comb begin
        in_d    = enq_go  ? ring_add(in_q,  CNT_W'(1)) : in_q;
        out_d   = free_go ? ring_add(out_q, CNT_W'(1)) : out_q;
        total_d = total_q + CNT_W'(enq_go) - CNT_W'(free_go);
    end

    // next state
    always_comb begin
        if (st_q == ST_FAULT || mismatch) st_d = ST_FAULT;
        else if (|s_pend_nxt)             st_d = ST_WRITE;
        else if (total_d == '0)           st_d = ST_EMPTY;
        else                              st_d = ST_COUNT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_EMPTY;
            in_q    <= '0;
            out_q   <= '0;
            total_q <= '0;
        end else begin
            st_q    <= st_d;
            in_q    <= in_d;
            out_q   <= out_d;
            total_q <= total_d;
        end
    end

    // output register: one write per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_dest <= '0;
            wr_mask <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= issue_go;
            if (issue_go) begin
                wr_dest <= s_dest[pick_idx];
                wr_mask <= fmt_mask;
                wr_data <= fmt_data;
            end
        end
    end

    assign fault = (st_q == ST_FAULT);

    AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) total_q <= CNT_W'(SLOTS)); // R2
    AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (enq_valid && enq_full) |=> (in_q == $past(in_q))); // R2
    AST_HEAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (s_valid[out_q] && !s_done[out_q]) |=> (out_q == $past(out_q))); // R9
    AST_WR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (($onehot(wr_mask) && (wr_data == '0 || wr_data == wr_mask)) || (wr_mask == '1) || (wr_mask == LOW_ONES && (wr_data & ~LOW_ONES) == '0))); // R6
    AST_STATE_PEND: assert property (@(posedge clk) disable iff (!rst_n) (st_q != ST_FAULT) |-> ((st_q == ST_WRITE) == (|s_pend))); // R8
    AST_EMPTY_STATE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_EMPTY) |-> (total_q == '0 && s_valid == '0)); // R1
    AST_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) !fault); // R11

endmodule

// File: tb/tb_delay_wr_queue.sv
module tb_delay_wr_queue;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        enq_valid;
    logic [4:0]  enq_dest;
    logic [3:0]  enq_delay;
    logic        enq_bit_mode;
    logic [5:0]  enq_bit;
    logic        enq_wide;
    logic [63:0] enq_value;
    logic        enq_full;
    logic        wr_en;
    logic [4:0]  wr_dest;
    logic [63:0] wr_mask;
    logic [63:0] wr_data;
    logic        fault;

    delay_wr_queue dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .enq_valid(enq_valid), .enq_dest(enq_dest), .enq_delay(enq_delay),
        .enq_bit_mode(enq_bit_mode), .enq_bit(enq_bit), .enq_wide(enq_wide),
        .enq_value(enq_value), .enq_full(enq_full),
        .wr_en(wr_en), .wr_dest(wr_dest), .wr_mask(wr_mask), .wr_data(wr_data),
        .fault(fault)
    );

    always #4 clk = ~clk; // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;
    bit fault_seen = 1'b0;

    int          lg_cyc  [512];
    logic [4:0]  lg_dest [512];
    logic [63:0] lg_mask [512];
    logic [63:0] lg_data [512];
    int          nlog = 0;

    always @(negedge clk) begin
        if (rst_n && fault) fault_seen = 1'b1;
        if (rst_n && wr_en && nlog < 512) begin
            lg_cyc[nlog]  = cyc;
            lg_dest[nlog] = wr_dest;
            lg_mask[nlog] = wr_mask;
            lg_data[nlog] = wr_data;
            nlog++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // called at a negedge; returns the edge number that samples the entry
    task automatic enq(input int dest, input int dly, input bit bm, input int bitn,
                       input bit wide, input logic [63:0] val, output int e);
        enq_valid    = 1'b1;
        enq_dest     = 5'(dest);
        enq_delay    = 4'(dly);
        enq_bit_mode = bm;
        enq_bit      = 6'(bitn);
        enq_wide     = wide;
        enq_value    = val;
        @(negedge clk);
        enq_valid = 1'b0;
        e = cyc;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int e, n0, x, eh;
        logic [63:0] v, m, d;
        rst_n = 1'b0; tick = 1'b0; enq_valid = 1'b0; enq_dest = '0; enq_delay = '0;
        enq_bit_mode = 1'b0; enq_bit = '0; enq_wide = 1'b0; enq_value = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!enq_full && !wr_en && !fault, "R1 reset", {enq_full, wr_en, fault}, 0);

        // R3 latency sweep over all delays, with word writes (R6)
        tick = 1'b1;
        for (int dl = 0; dl < 16; dl++) begin
            n0 = nlog;
            v  = 64'hA5A5_0000_0000_0000 | 64'(dl);
            enq(dl, dl, 1'b0, 0, 1'b1, v, e);
            wait_to(e + dl + 5);
            chk(nlog == n0 + 1, "R3 one write", nlog - n0, 1);
            chk(lg_cyc[n0] == e + ((dl == 0) ? 1 : dl) + 1, "R3 latency", lg_cyc[n0], e + ((dl == 0) ? 1 : dl) + 1);
            chk(lg_dest[n0] == 5'(dl) && lg_mask[n0] == '1 && lg_data[n0] == v, "R6 word64",
                {lg_mask[n0], lg_data[n0]}, {64'hFFFF_FFFF_FFFF_FFFF, v});
        end

        // R4 R5 R7 bit sweep
        for (int b = 0; b < 64; b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 2; s++) begin
                    n0 = nlog;
                    v  = (s == 1) ? (64'h1 << ((b * 7) % 64)) : 64'h0;
                    enq(b % 32, 1, 1'b1, b, w[0], v, e);
                    wait_to(e + 4);
                    m = 64'h1 << ((w == 1) ? b : (b % 32));
                    d = (s == 1) ? m : 64'h0;
                    chk(nlog == n0 + 1 && lg_mask[n0] == m && lg_data[n0] == d,
                        (s == 1) ? ((w == 1) ? "R4 set64" : "R7 set32") : ((w == 1) ? "R5 clr64" : "R7 clr32"),
                        {lg_mask[n0], lg_data[n0]}, {m, d});
                end
            end
        end

        // R6 narrow word write
        n0 = nlog;
        enq(9, 2, 1'b0, 0, 1'b0, 64'hDEAD_BEEF_1234_5678, e);
        wait_to(e + 6);
        chk(lg_mask[n0] == 64'h0000_0000_FFFF_FFFF && lg_data[n0] == 64'h0000_0000_1234_5678, "R6 word32",
            {lg_mask[n0], lg_data[n0]}, {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_1234_5678});

        // R3 no countdown while tick is low
        tick = 1'b0;
        n0 = nlog;
        enq(5, 3, 1'b0, 0, 1'b1, 64'h55, e);
        wait_to(e + 6);
        chk(nlog == n0, "R3 tick low holds", nlog - n0, 0);
        x = cyc;
        tick = 1'b1;
        wait_to(x + 7);
        chk(nlog == n0 + 1 && lg_cyc[n0] == x + 4, "R3 tick gated latency", lg_cyc[n0], x + 4);

        // R8 coincident expiry
        tick = 1'b0;
        n0 = nlog;
        for (int k = 1; k <= 3; k++) enq(k, 2, 1'b0, 0, 1'b1, 64'(k), e);
        x = cyc;
        tick = 1'b1;
        wait_to(x + 9);
        chk(nlog == n0 + 3, "R8 count", nlog - n0, 3);
        for (int k = 0; k < 3; k++)
            chk(lg_dest[n0+k] == 5'(k + 1) && lg_cyc[n0+k] == x + 3 + k, "R8 order",
                {lg_dest[n0+k], lg_cyc[n0+k]}, {5'(k + 1), x + 3 + k});

        // R9 R10 head blocks reclaim
        n0 = nlog;
        enq(10, 15, 1'b0, 0, 1'b1, 64'hBEEF, eh);
        for (int k = 11; k <= 17; k++) enq(k, 1, 1'b1, k, 1'b1, 64'h1, e);
        chk(enq_full == 1'b1, "R2 full at SLOTS", enq_full, 1);
        wait_to(eh + 10);
        enq(30, 1, 1'b0, 0, 1'b1, 64'h30, e);
        wait_to(eh + 16);
        chk(enq_full == 1'b1, "R9 full while head pending", enq_full, 1);
        wait_to(eh + 17);
        chk(enq_full == 1'b0, "R10 full drops after head write", enq_full, 0);
        wait_to(eh + 20);
        chk(nlog == n0 + 8, "R2 dropped entry absent", nlog - n0, 8);
        for (int k = 0; k < 7; k++)
            chk(lg_dest[n0+k] == 5'(11 + k) && lg_cyc[n0+k] == eh + 3 + k, "R9 young first",
                {lg_dest[n0+k], lg_cyc[n0+k]}, {5'(11 + k), eh + 3 + k});
        chk(lg_dest[n0+7] == 5'd10 && lg_cyc[n0+7] == eh + 16, "R9 head last",
            {lg_dest[n0+7], lg_cyc[n0+7]}, {5'd10, eh + 16});

        // R10 every slot reusable
        wait_to(eh + 30);
        tick = 1'b0;
        n0 = nlog;
        for (int k = 0; k < 7; k++) enq(20 + k, 1, 1'b0, 0, 1'b1, 64'(k), e);
        chk(enq_full == 1'b0, "R10 seven held", enq_full, 0);
        enq(27, 1, 1'b0, 0, 1'b1, 64'h7, e);
        chk(enq_full == 1'b1, "R10 eight held", enq_full, 1);
        x = cyc;
        tick = 1'b1;
        wait_to(x + 20);
        chk(nlog == n0 + 8 && enq_full == 1'b0, "R10 drained", nlog - n0, 8);
        for (int k = 0; k < 8; k++)
            chk(lg_dest[n0+k] == 5'(20 + k), "R8 drain order", lg_dest[n0+k], 5'(20 + k));

        // R11 no fault in legal operation
        chk(!fault_seen, "R11 fault low", fault_seen, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule